// File: doc/BRIEF.md
# Latchable Fault Status Register

This block reports the state of a small bank of fault inputs in a PWM controller. Each raw fault line is asynchronous. It passes through a two-flop synchronizer and then a per-input polarity stage, so that active-low and active-high faults both read as 1 when active. Software reads the result through one status word.

A single mode pin selects how the word reads. With the mode pin low, the word is a live, read-only view of the adjusted inputs. With it high, each bit is a sticky flag. A flag sets once its adjusted input goes active and stays set until software writes a 1 to that bit. When the mode pin drops, every flag is cleared, so the next latched session starts from zero.

The register interface is plain: a write strobe, write data and read data. There is no handshake.

Top module: `fault_status_reg`

## Requirements
- R1: Reset (`rst_n` low) clears the synchronizer stages and all sticky flags. After reset, with `sense_invert` zero, `rd_data` reads 0 in both modes until an input goes active.
- R2: With `latch_mode` low, `rd_data` shows the adjusted fault inputs. A change on `fault_in` that is stable at a rising edge appears on `rd_data` two clock edges later.
- R3: `sense_invert[i]`=1 inverts fault input i before it is reported or latched. `sense_invert[i]`=0 passes the input through unchanged.
- R4: With `latch_mode` high, flag i sets on the first rising edge at which adjusted input i is 1. It stays 1 after the input returns inactive.
- R5: With `latch_mode` high, a cycle with `wr_en`=1 clears each flag whose `wr_data` bit is 1 at the next edge. Flags whose `wr_data` bit is 0 keep their value.
- R6: When a clear for bit i and an active adjusted input i fall in the same cycle, flag i ends up 1.
- R7: With `latch_mode` low, writes change nothing that `rd_data` shows.
- R8: A rising edge with `latch_mode` low clears every flag. When latch mode is turned on again, `rd_data` reads 0 until a new fault occurs.
- R9: Bit i of `rd_data` and of `wr_data` belongs to `fault_in[i]`. With the default of three inputs, the status bits are 2, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fault_in | input | NUM_FAULTS | Raw asynchronous fault lines |
| sense_invert | input | NUM_FAULTS | Per-input polarity; 1 inverts the line |
| latch_mode | input | 1 | 0 = live read-only view, 1 = sticky write-1-to-clear flags |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | NUM_FAULTS | Write data; a 1 clears that flag in latch mode |
| rd_data | output | NUM_FAULTS | Status word |

## Verification
A flag stuck at 0 or 1, or a clear that reaches the wrong bit, shows up on `rd_data` on the clock after the write or fault edge while latch mode is on. A synchronizer that is one stage too short or too long shifts every live transition by a cycle, which is visible within three clocks of any input change. Flags left stale across a mode change appear on the first cycle after latch mode turns back on.

// File: rtl/fstat_pkg.sv
package fstat_pkg;
  localparam int unsigned FSTAT_DEFAULT_N      = 3;
  localparam int unsigned FSTAT_DEFAULT_STAGES = 2;

  typedef enum logic {
    VIEW_LIVE  = 1'b0,
    VIEW_STICK = 1'b1
  } fstat_view_e;
endpackage

// File: rtl/fstat_sync.sv
module fstat_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[k] <= '0;
      else        chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fstat_sense.sv
module fstat_sense #(
  parameter int unsigned WIDTH = 3
) (
  input  logic [WIDTH-1:0] raw,
  input  logic [WIDTH-1:0] invert,
  output logic [WIDTH-1:0] adj
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    // R3: a 1 in the polarity bit flips an active-low line to active-high
    assign adj[i] = invert[i] ? ~raw[i] : raw[i];
  end
endmodule

// File: rtl/fstat_flags.sv
module fstat_flags #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stick_en,
  input  logic [WIDTH-1:0] adj,
  input  logic [WIDTH-1:0] clr_mask,
  output logic [WIDTH-1:0] flags
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flags[i] <= 1'b0;
      else if (!stick_en) flags[i] <= 1'b0;       // R8
      else if (adj[i])    flags[i] <= 1'b1;       // R4, R6: set beats clear
      else if (clr_mask[i]) flags[i] <= 1'b0;     // R5
    end
  end

  assert_clear_when_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stick_en |=> (flags == '0));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stick_en |=> (($past(adj) & ~flags) == '0));

  assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stick_en |=> ((($past(flags) & ~$past(clr_mask)) & ~flags) == '0));
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
  import fstat_pkg::*;
#(
  parameter int unsigned NUM_FAULTS  = FSTAT_DEFAULT_N,
  parameter int unsigned SYNC_STAGES = FSTAT_DEFAULT_STAGES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_FAULTS-1:0] fault_in,
  input  logic [NUM_FAULTS-1:0] sense_invert,
  input  logic                  latch_mode,
  input  logic                  wr_en,
  input  logic [NUM_FAULTS-1:0] wr_data,
  output logic [NUM_FAULTS-1:0] rd_data
);
  localparam int unsigned W = NUM_FAULTS;

  fstat_view_e  view;
  logic [W-1:0] synced;
  logic [W-1:0] adjusted;
  logic [W-1:0] clr_mask;
  logic [W-1:0] flags;

  assign view     = latch_mode ? VIEW_STICK : VIEW_LIVE;
  assign clr_mask = wr_en ? wr_data : '0;   // R7: only matters while sticky

  fstat_sync #(.WIDTH(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(fault_in), .q(synced)
  );

  fstat_sense #(.WIDTH(W)) u_sense (
    .raw(synced), .invert(sense_invert), .adj(adjusted)
  );

  fstat_flags #(.WIDTH(W)) u_flags (
    .clk(clk), .rst_n(rst_n), .stick_en(view == VIEW_STICK),
    .adj(adjusted), .clr_mask(clr_mask), .flags(flags)
  );

  always_comb begin
    unique case (view)
      VIEW_STICK: rd_data = flags;      // R4, R9
      default:    rd_data = adjusted;   // R2, R9
    endcase
  end

  assert_fresh_session_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_mode) |-> (rd_data == '0));
endmodule

// File: tb/fault_status_reg_tb_top.sv
module fault_status_reg_tb_top;
  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] fault_in = '0;
  logic [N-1:0] sense_invert = '0;
  logic         latch_mode = 1'b0;
  logic         wr_en = 1'b0;
  logic [N-1:0] wr_data = '0;
  logic [N-1:0] rd_data;

  always #2 clk = ~clk;   // 250 MHz

  fault_status_reg dut_i (
    .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .sense_invert(sense_invert),
    .latch_mode(latch_mode), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string req   = "R1";
  bit    done  = 1'b0;

  // Behavioural reference: two delayed copies of the raw inputs and the sticky flags
  int m_s1 = 0, m_s2 = 0, m_flag = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_flag = 0;
    end else begin
      int adj_now;
      adj_now = m_s2 ^ int'(sense_invert);
      if (!latch_mode) m_flag = 0;
      else begin
        if (wr_en) m_flag = m_flag & ~int'(wr_data);
        m_flag = (m_flag | adj_now) & 7;
      end
      m_s2 = m_s1;
      m_s1 = int'(fault_in);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      int exp_v;
      exp_v = latch_mode ? m_flag : ((m_s2 ^ int'(sense_invert)) & 7);
      n_cmp++;
      if (int'(rd_data) !== exp_v) begin
        n_bad++;
        $display("FAIL %s: rd_data actual=%b expected=%b at %0t", req, rd_data, exp_v[N-1:0], $time);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_word(input logic [N-1:0] v);
    wr_en = 1'b1; wr_data = v;
    tick(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    req = "R1";
    tick(3);
    rst_n = 1'b1;
    tick(3);
    latch_mode = 1'b1; tick(3); latch_mode = 1'b0; tick(1);

    req = "R2";
    for (int p = 1; p < 8; p++) begin
      fault_in = p[N-1:0]; tick(1); tick(3);
    end
    fault_in = '0; tick(4);

    req = "R9";
    fault_in = 3'b001; tick(4);
    fault_in = 3'b010; tick(4);
    fault_in = 3'b100; tick(4);
    fault_in = '0;     tick(4);

    req = "R3";
    sense_invert = 3'b101; tick(3);
    fault_in = 3'b101; tick(4);
    fault_in = 3'b010; tick(4);
    sense_invert = 3'b111; tick(3);
    sense_invert = '0; fault_in = '0; tick(4);

    req = "R7";
    fault_in = 3'b110; tick(4);
    write_word(3'b111); tick(2);
    write_word(3'b010); tick(2);
    fault_in = '0; tick(4);

    req = "R4";
    latch_mode = 1'b1; tick(2);
    fault_in = 3'b010; tick(1); fault_in = '0; tick(6);
    fault_in = 3'b100; tick(1); fault_in = '0; tick(6);

    req = "R5";
    write_word(3'b000); tick(2);
    write_word(3'b010); tick(2);
    write_word(3'b100); tick(2);
    fault_in = 3'b011; tick(1); fault_in = '0; tick(4);
    write_word(3'b001); tick(2);

    req = "R6";
    fault_in = 3'b001; tick(4);
    write_word(3'b001); tick(2);
    fault_in = '0; tick(3);
    write_word(3'b011); tick(2);

    req = "R3";
    sense_invert = 3'b100; tick(4);
    write_word(3'b100); tick(2);
    sense_invert = '0; tick(3);
    write_word(3'b111); tick(2);

    req = "R8";
    fault_in = 3'b111; tick(1); fault_in = '0; tick(5);
    latch_mode = 1'b0; tick(2);
    latch_mode = 1'b1; tick(4);
    fault_in = 3'b100; tick(1); fault_in = '0; tick(4);
    latch_mode = 1'b0; tick(1); latch_mode = 1'b1; tick(3);

    req = "R1";
    fault_in = 3'b011; tick(1); fault_in = '0; tick(4);
    rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(4);
    latch_mode = 1'b0; tick(3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule